// File: doc/BRIEF.md
# Iambic Morse Paddle Keyer

This block turns two active-high paddle contacts, one for dits and one for dahs, into a timed Morse key line and a gated square-wave sidetone. A prescaler divides the clock into Morse units, and a small unit counter times each element. A dit is one unit of key-on and a dah is three. Every element is followed by one unit of key-off.

The keyer keeps one bit saying whether the element on the air is a dit or a dah. A second bit notes a press of the opposite paddle at any point in that element, mark or gap. When both paddles are squeezed, the elements therefore alternate, beginning with the paddle that closed first. A paddle held alone repeats its element. With nothing pressed and nothing remembered, the keyer returns to idle. The unit length is taken from its input only while idle, so an element in flight keeps its timing.

The controller has three states. `ST_IDLE` waits for a paddle. It leaves by *start* to `ST_MARK` and latches the unit length. `ST_MARK` holds the key on. It leaves by *mark_done* to `ST_GAP` when its last unit ends. `ST_GAP` holds the key off for one unit and then takes one of three exits: *next_opposite* (memory set) or *repeat* (same paddle held) back to `ST_MARK`, or *release* to `ST_IDLE`.

Top module: `iambic_keyer`

## Requirements
- R1: During and after synchronous reset, with no paddle pressed, `key_out` and `tone_out` are low and the keyer is idle.
- R2: Each paddle input is active high and passes through a two-flop synchroniser. A press lasting a single clock cycle is enough to start an element from idle.
- R3: With L = `unit_len`, where a value of 0 counts as 1, a dit holds `key_out` high for exactly L cycles and a dah for exactly 3L cycles.
- R4: Between two consecutive elements of a sequence, `key_out` is low for exactly L cycles.
- R5: While only one paddle is held, its element repeats, one after another.
- R6: A press of the opposite paddle at any time during the current element, mark or gap, makes the opposite element come next. The memory clears when that element begins.
- R7: While both paddles are held, the elements alternate, starting with the element of the paddle that closed first.
- R8: If both paddles are first seen in the same idle cycle, a dit is sent first.
- R9: At the end of a gap with no paddle pressed and no memory set, the keyer returns to idle with the key off.
- R10: `unit_len` is sampled only while idle. Changing it during an element leaves that element's timing unchanged.
- R11: `tone_out` is low whenever `key_out` is low. With H = `tone_half`, where 0 counts as 1, `tone_out` in mark cycle k (counting from 0) is high exactly when floor(k/H) is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dit_paddle | input | 1 | Dit paddle contact, active high, asynchronous |
| dah_paddle | input | 1 | Dah paddle contact, active high, asynchronous |
| unit_len | input | UNIT_W | Clock cycles per Morse unit (0 treated as 1) |
| tone_half | input | TONE_W | Sidetone half-period in clock cycles (0 treated as 1) |
| key_out | output | 1 | Key line, high during the mark of an element |
| tone_out | output | 1 | Sidetone square wave, gated by the key |

## Verification
The embedded assertions check several properties on every cycle. The unit prescaler stays below the latched length, and that length holds still outside idle. The memory is clear whenever a mark starts, and a dit wins a simultaneous idle press. A remembered press always flips the element, a mark never drops straight to idle, and the tone divider is held in its rest state while the key is off. The exact mark and gap lengths in cycles, alternation over a full squeeze, repetition under a held paddle, and the return to idle can only be shown end to end. The bench shows them by measuring `key_out` run lengths over a sweep of unit lengths and paddle patterns, and it compares every mark cycle of the tone against the arithmetic square wave.

// File: rtl/keyer_pkg.sv
package keyer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MARK = 2'd1,
        ST_GAP  = 2'd2
    } keyer_state_e;

    typedef enum logic {
        EL_DIT = 1'b0,
        EL_DAH = 1'b1
    } element_e;

    localparam int DIT_UNITS = 1;
    localparam int DAH_UNITS = 3;
    localparam int UCNT_W    = $clog2(DAH_UNITS);

endpackage

// File: rtl/keyer_sync.sv
module keyer_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[g-1].q;
            end
        end
    end

    assign d_out = g_stage[STAGES-1].q;

endmodule

// File: rtl/keyer_unit_timer.sv
module keyer_unit_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [LEN_W-1:0] len,
    output logic             unit_tick
);

    logic [LEN_W-1:0] pre_cnt;

    assign unit_tick = !hold && (pre_cnt == len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || hold || unit_tick) pre_cnt <= '0;
        else                          pre_cnt <= pre_cnt + LEN_W'(1);
    end

    // R3: prescaler never runs past the latched unit length
    a_r3_prescaler_bound: assert property (@(posedge clk) disable iff (rst)
        pre_cnt < len);

endmodule

// File: rtl/keyer_tone.sv
module keyer_tone #(
    parameter int HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key,
    input  logic [HALF_W-1:0] half,
    output logic              tone
);

    logic [HALF_W-1:0] cnt;
    logic              phase;
    logic [HALF_W-1:0] half_last;

    assign half_last = (half == '0) ? '0 : half - HALF_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !key) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt >= half_last) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + HALF_W'(1);
        end
    end

    assign tone = key & ~phase;

    // R11: divider restarts from rest whenever the key drops
    a_r11_tone_rest: assert property (@(posedge clk) disable iff (rst)
        !key |=> (cnt == '0 && !phase));

endmodule

// File: rtl/iambic_keyer.sv
module iambic_keyer
    import keyer_pkg::*;
#(
    parameter int UNIT_W      = 16,
    parameter int TONE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dit_paddle,
    input  logic              dah_paddle,
    input  logic [UNIT_W-1:0] unit_len,
    input  logic [TONE_W-1:0] tone_half,
    output logic              key_out,
    output logic              tone_out
);

    localparam logic [UCNT_W-1:0] DIT_LAST = UCNT_W'(DIT_UNITS - 1);
    localparam logic [UCNT_W-1:0] DAH_LAST = UCNT_W'(DAH_UNITS - 1);

    logic [1:0]        pad_s;
    logic              dit_s, dah_s, opp_now;
    logic              unit_tick;

    keyer_state_e      state_q, state_n;
    element_e          elem_q, elem_n;
    logic              mem_q, mem_n;
    logic [UCNT_W-1:0] ucnt_q, ucnt_n;
    logic [UNIT_W-1:0] len_q, len_n;
    logic [UCNT_W-1:0] mark_last;

    keyer_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({dah_paddle, dit_paddle}),
        .d_out (pad_s)
    );

    assign dit_s     = pad_s[0];
    assign dah_s     = pad_s[1];
    assign opp_now   = (elem_q == EL_DIT) ? dah_s : dit_s;
    assign mark_last = (elem_q == EL_DAH) ? DAH_LAST : DIT_LAST;

    keyer_unit_timer #(.LEN_W(UNIT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hold      (state_q == ST_IDLE),
        .len       (len_q),
        .unit_tick (unit_tick)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        elem_n  = elem_q;
        mem_n   = mem_q;
        ucnt_n  = ucnt_q;
        len_n   = len_q;
        unique case (state_q)
            ST_IDLE: begin
                len_n  = (unit_len == '0) ? UNIT_W'(1) : unit_len;
                ucnt_n = '0;
                mem_n  = 1'b0;
                if (dit_s || dah_s) begin                      // start
                    state_n = ST_MARK;
                    elem_n  = dit_s ? EL_DIT : EL_DAH;
                end
            end
            ST_MARK: begin
                if (opp_now) mem_n = 1'b1;
                if (unit_tick) begin
                    if (ucnt_q == mark_last) begin             // mark_done
                        state_n = ST_GAP;
                        ucnt_n  = '0;
                    end else begin
                        ucnt_n  = ucnt_q + UCNT_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (opp_now) mem_n = 1'b1;
                if (unit_tick) begin
                    mem_n = 1'b0;
                    if (mem_q || opp_now) begin                // next_opposite
                        state_n = ST_MARK;
                        elem_n  = (elem_q == EL_DIT) ? EL_DAH : EL_DIT;
                    end else if (elem_q == EL_DIT ? dit_s : dah_s) begin
                        state_n = ST_MARK;                     // repeat
                    end else begin
                        state_n = ST_IDLE;                     // release
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            elem_q  <= EL_DIT;
            mem_q   <= 1'b0;
            ucnt_q  <= '0;
            len_q   <= UNIT_W'(1);
        end else begin
            state_q <= state_n;
            elem_q  <= elem_n;
            mem_q   <= mem_n;
            ucnt_q  <= ucnt_n;
            len_q   <= len_n;
        end
    end

    // outputs
    always_comb begin
        key_out = (state_q == ST_MARK);
    end

    keyer_tone #(.HALF_W(TONE_W)) u_tone (
        .clk  (clk),
        .rst  (rst),
        .key  (key_out),
        .half (tone_half),
        .tone (tone_out)
    );

    // R1: reset leaves the keyer idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && !mem_q));

    // R3: unit counter stays inside a dah
    a_r3_unit_bound: assert property (@(posedge clk) disable iff (rst)
        ucnt_q <= DAH_LAST);

    // R6: memory is clear when a mark begins
    a_r6_mem_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(key_out) |-> !mem_q);

    // R6: remembered press flips the element
    a_r6_mem_flips: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP && mem_q && unit_tick) |=>
            (state_q == ST_MARK && elem_q != $past(elem_q)));

    // R8: dit wins a simultaneous idle press
    a_r8_dit_first: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && dit_s && dah_s) |=> elem_q == EL_DIT);

    // R9: a mark always passes through a gap before idle
    a_r9_gap_before_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MARK) |=> state_q != ST_IDLE);

    // R10: unit length only changes while idle
    a_r10_len_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(len_q));

endmodule

// File: tb/test_iambic_keyer.sv
module test_iambic_keyer;

    localparam int UNIT_W = 16;
    localparam int TONE_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dit_p = 1'b0;
    logic              dah_p = 1'b0;
    logic [UNIT_W-1:0] unit_len = UNIT_W'(2);
    logic [TONE_W-1:0] tone_half = TONE_W'(1);
    logic              key_out, tone_out;

    int checks = 0;
    int errors = 0;

    iambic_keyer #(.UNIT_W(UNIT_W), .TONE_W(TONE_W)) i_iambic_keyer (
        .clk        (clk),
        .rst        (rst),
        .dit_paddle (dit_p),
        .dah_paddle (dah_p),
        .unit_len   (unit_len),
        .tone_half  (tone_half),
        .key_out    (key_out),
        .tone_out   (tone_out)
    );

    always #5 clk = ~clk;

    // run-length monitor on the key line
    int rises = 0, falls = 0, hi = 0, lo = 0, tone_err = 0, h_eff = 1;
    int marks[16];
    int gaps[16];
    bit mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (key_out) begin
                if (hi == 0) begin
                    if (rises > 0 && rises <= 16) gaps[rises-1] = lo;
                    rises++;
                end
                if (tone_out != (((hi / h_eff) % 2) == 0)) tone_err++;
                hi++;
                lo = 0;
            end else begin
                if (hi > 0) begin
                    if (rises <= 16) marks[rises-1] = hi;
                    falls++;
                end
                if (tone_out) tone_err++;
                hi = 0;
                lo++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_rise(input int k);
        while (rises < k) tick();
    endtask

    task automatic wait_fall(input int k);
        while (falls < k) tick();
    endtask

    task automatic mon_start();
        rises = 0; falls = 0; hi = 0; lo = 0; tone_err = 0;
        mon_on = 1'b1;
    endtask

    task automatic tap(input bit on_dit, input bit on_dah);
        dit_p = on_dit; dah_p = on_dah;
        tick();
        dit_p = 1'b0; dah_p = 1'b0;
    endtask

    int exp_n;
    int exp_m[8];

    task automatic finish_scn(input string req, input int leff);
        repeat (8 * leff + 20) tick();
        chk(rises == exp_n, req, "element count", rises, exp_n);
        for (int i = 0; i < exp_n && i < rises; i++) begin
            chk(marks[i] == exp_m[i], req, "mark length", marks[i], exp_m[i]);
            if (i < exp_n - 1)
                chk(gaps[i] == leff, "R4", "gap length", gaps[i], leff);
        end
        chk(tone_err == 0, "R11", "tone mismatches", tone_err, 0);
        chk(key_out == 1'b0, "R9", "key idle after sequence", int'(key_out), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) tick();
        chk(key_out == 1'b0, "R1", "key in reset", int'(key_out), 0);
        chk(tone_out == 1'b0, "R1", "tone in reset", int'(tone_out), 0);
        repeat (3) tick();
        rst = 1'b0;
        repeat (4) tick();
        chk(key_out == 1'b0, "R1", "key after reset", int'(key_out), 0);
        chk(tone_out == 1'b0, "R1", "tone after reset", int'(tone_out), 0);

        for (int li = 0; li < 3; li++) begin
            int L;
            L = (li == 0) ? 2 : (li == 1) ? 3 : 5;
            unit_len  = UNIT_W'(L);
            tone_half = TONE_W'(L - 1);
            h_eff     = L - 1;

            // R2 R3: single-cycle dit tap
            mon_start(); tap(1'b1, 1'b0);
            exp_n = 1; exp_m[0] = L;
            finish_scn("R3", L);

            // R2 R3: single-cycle dah tap
            mon_start(); tap(1'b0, 1'b1);
            exp_n = 1; exp_m[0] = 3 * L;
            finish_scn("R3", L);

            // R5: held dit repeats
            mon_start(); dit_p = 1'b1; wait_rise(3); dit_p = 1'b0;
            exp_n = 3; exp_m[0] = L; exp_m[1] = L; exp_m[2] = L;
            finish_scn("R5", L);

            // R5: held dah repeats
            mon_start(); dah_p = 1'b1; wait_rise(3); dah_p = 1'b0;
            exp_n = 3; exp_m[0] = 3*L; exp_m[1] = 3*L; exp_m[2] = 3*L;
            finish_scn("R5", L);

            // R7: squeeze starting with dit
            mon_start(); dit_p = 1'b1; wait_rise(1); dah_p = 1'b1;
            wait_fall(3); dit_p = 1'b0; dah_p = 1'b0;
            exp_n = 4; exp_m[0] = L; exp_m[1] = 3*L; exp_m[2] = L; exp_m[3] = 3*L;
            finish_scn("R7", L);

            // R7: squeeze starting with dah
            mon_start(); dah_p = 1'b1; wait_rise(1); dit_p = 1'b1;
            wait_fall(3); dit_p = 1'b0; dah_p = 1'b0;
            exp_n = 4; exp_m[0] = 3*L; exp_m[1] = L; exp_m[2] = 3*L; exp_m[3] = L;
            finish_scn("R7", L);

            // R8: both paddles in the same cycle, dit first
            mon_start(); dit_p = 1'b1; dah_p = 1'b1;
            wait_fall(1); dit_p = 1'b0; dah_p = 1'b0;
            exp_n = 2; exp_m[0] = L; exp_m[1] = 3 * L;
            finish_scn("R8", L);

            // R6: brief opposite tap during a dit is remembered
            mon_start(); tap(1'b1, 1'b0); wait_rise(1); tap(1'b0, 1'b1);
            exp_n = 2; exp_m[0] = L; exp_m[1] = 3 * L;
            finish_scn("R6", L);

            // R10: unit_len change mid-element ignored
            mon_start(); tap(1'b0, 1'b1); wait_rise(1);
            unit_len = UNIT_W'(L + 4);
            wait_fall(1);
            unit_len = UNIT_W'(L);
            exp_n = 1; exp_m[0] = 3 * L;
            finish_scn("R10", L);
        end

        // R3 R11: zero unit length and zero half-period count as one
        unit_len = '0; tone_half = '0; h_eff = 1;
        mon_start(); tap(1'b1, 1'b0);
        exp_n = 1; exp_m[0] = 1;
        finish_scn("R3", 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule